// File: doc/BRIEF.md
# Back-to-back instruction dependency detector

This block decides, without a clock, whether an instruction must wait for the instruction issued just before it. It works on two descriptors that an upstream decoder has already built. The older instruction is described by four things: whether it has a destination, that destination's register number, whether the destination is a memory location addressed by a base register plus an offset (a store), and whether it writes the condition flag. The younger instruction supplies up to three source slots and one flag-read bit. Each source slot has a valid bit, a register number and a kind.

The output `depend` is high when the younger instruction cannot be paired with, or issued directly behind, the older one. An issue stage or a pairing check uses it to insert a bubble or to split a dual-issue group. The memory rules are one-sided. A store never blocks a later plain register read. A store followed by any address-forming operand always blocks, so that a load cannot pass a store that is still pending. A flag write followed by a flag read always blocks.

Top module: `dep_hazard_check`

## Requirements
- R1: When `prv_wr_flag` and `nxt_rd_flag` are both 1, `depend` is 1 whatever the other inputs are.
- R2: When `prv_has_dst` is 0 and R1 does not apply, `depend` is 0.
- R3: A source slot with its valid bit at 0, or with kind 0 (immediate), never causes a dependency. Kind 3 is reserved and is treated as immediate.
- R4: If the older instruction has a register destination (`prv_dst_mem`=0) and a slot has kind 1 (plain register), that slot causes a dependency exactly when its register number equals `prv_dst_reg`.
- R5: If the older instruction has a register destination and a slot has kind 2 (base register of an address), that slot causes a dependency exactly when the register numbers are equal.
- R6: If the older instruction has a memory destination (`prv_dst_mem`=1), a kind 1 slot never causes a dependency, even when the register numbers are equal.
- R7: If the older instruction has a memory destination, every valid kind 2 slot causes a dependency, whatever its register number.
- R8: Register 0 is compared like any other register number. A younger store presents its base register as a kind 2 slot and is matched by the same rules.
- R9: Slot i uses register bits [5i+4:5i] of `nxt_src_reg` and kind bits [2i+1:2i] of `nxt_src_kind`. `depend` is the OR of the R1 result and the results of all three slots.
- R10: `depend` is a pure function of the current inputs. It is valid in the same cycle the inputs are applied and holds no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| prv_has_dst | input | 1 | Older instruction has a destination operand |
| prv_dst_reg | input | 5 | Older instruction's destination register, or its base register for a store |
| prv_dst_mem | input | 1 | Older destination is a memory location (store) |
| prv_wr_flag | input | 1 | Older instruction writes the condition flag |
| nxt_src_vld | input | 3 | Valid bit for each younger source slot |
| nxt_src_reg | input | 15 | Register number for each slot, 5 bits per slot |
| nxt_src_kind | input | 6 | Kind for each slot: 0 immediate, 1 register, 2 base, 3 reserved |
| nxt_rd_flag | input | 1 | Younger instruction reads the condition flag |
| depend | output | 1 | Younger instruction depends on the older one |

## Verification
Directed patterns cover each pairing of destination form and source kind twice: once with equal register numbers and once with different ones. A register-to-register pair therefore shows up as a match test, while a store against a plain read and a store against a base operand show that the register number is ignored in those cases. Flag cases are applied with no destination and with all slots immediate, which separates the flag rule from operand matching. Invalid slots, the reserved kind, register 0 and a hit placed in each slot position check the masking and the slot layout. A long pseudo-random sweep is then compared against a behavioural model on every clock.

// File: rtl/dep_pkg.sv
// Package dep_pkg
// Holds the shared widths and the source-kind encoding used by the
// dependency detector and its sub-blocks. Assumes 5-bit register numbers
// and three source slots by default.
package dep_pkg;
    parameter int REG_W   = 5;
    parameter int NUM_SRC = 3;
    localparam int KIND_W = 2;

    typedef enum logic [KIND_W-1:0] {
        KIND_IMM  = 2'd0,
        KIND_REG  = 2'd1,
        KIND_BASE = 2'd2,
        KIND_RSV  = 2'd3
    } src_kind_e;
endpackage

// File: rtl/dep_flag_cmp.sv
// Module dep_flag_cmp
// Detects a flag write in the older instruction followed by a flag read in
// the younger one. Purely combinational; assumes both bits are decoded
// upstream.
module dep_flag_cmp (
    input  logic wr_flag,
    input  logic rd_flag,
    output logic flag_hit
);
    // Purpose: raise the hit when the flag is produced and then consumed.
    always_comb begin
        flag_hit = wr_flag & rd_flag;
    end
endmodule

// File: rtl/dep_operand_cmp.sv
// Module dep_operand_cmp
// Compares one younger source slot against the older instruction's
// destination. Immediate and reserved kinds never hit. A store destination
// hits every base operand and no plain register read. A register
// destination hits on an equal register number. Combinational.
module dep_operand_cmp
    import dep_pkg::*;
#(
    parameter int RW = REG_W
) (
    input  logic          has_dst,
    input  logic [RW-1:0] dst_reg,
    input  logic          dst_mem,
    input  logic          src_vld,
    input  logic [RW-1:0] src_reg,
    input  src_kind_e     src_kind,
    output logic          hit
);
    logic same_reg;

    // Purpose: compare register numbers (register 0 included).
    always_comb begin
        same_reg = (src_reg == dst_reg);
    end

    // Purpose: apply the per-kind conflict rule.
    always_comb begin
        hit = 1'b0;
        if (src_vld && has_dst) begin
            case (src_kind)
                KIND_REG:  hit = !dst_mem && same_reg;
                KIND_BASE: hit = dst_mem || same_reg;
                default:   hit = 1'b0;
            endcase
        end
    end

    // Purpose: guard the slot rules that must never be violated.
    always_comb begin
        if (src_kind == KIND_IMM || src_kind == KIND_RSV || !src_vld)
            assert_imm_never_R3: assert (!hit) else $error("R3 slot hit on immediate/invalid");
        if (dst_mem && src_kind == KIND_REG)
            assert_store_vs_read_R6: assert (!hit) else $error("R6 store hit plain read");
        if (has_dst && dst_mem && src_vld && src_kind == KIND_BASE)
            assert_store_vs_base_R7: assert (hit) else $error("R7 store missed base operand");
    end
endmodule

// File: rtl/dep_hazard_check.sv
// Module dep_hazard_check
// Top of the back-to-back dependency detector. Splits the flat slot buses,
// runs one operand comparator per slot and the flag comparator, and ORs
// every hit into depend. No clock or state. Assumes the descriptors come
// from a decoder and are stable while depend is used.
module dep_hazard_check
    import dep_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int NS = NUM_SRC
) (
    input  logic             prv_has_dst,
    input  logic [RW-1:0]    prv_dst_reg,
    input  logic             prv_dst_mem,
    input  logic             prv_wr_flag,
    input  logic [NS-1:0]    nxt_src_vld,
    input  logic [NS*RW-1:0] nxt_src_reg,
    input  logic [NS*2-1:0]  nxt_src_kind,
    input  logic             nxt_rd_flag,
    output logic             depend
);
    logic [NS-1:0] slot_hit;
    logic          flag_hit;

    dep_flag_cmp u_flag (
        .wr_flag  (prv_wr_flag),
        .rd_flag  (nxt_rd_flag),
        .flag_hit (flag_hit)
    );

    for (genvar gi = 0; gi < NS; gi++) begin : g_slot
        src_kind_e kind_s;

        // Purpose: recover the typed kind of this slot from the flat bus.
        always_comb begin
            kind_s = src_kind_e'(nxt_src_kind[gi*2 +: 2]);
        end

        dep_operand_cmp #(.RW(RW)) u_cmp (
            .has_dst  (prv_has_dst),
            .dst_reg  (prv_dst_reg),
            .dst_mem  (prv_dst_mem),
            .src_vld  (nxt_src_vld[gi]),
            .src_reg  (nxt_src_reg[gi*RW +: RW]),
            .src_kind (kind_s),
            .hit      (slot_hit[gi])
        );
    end

    // Purpose: merge the flag hit and all slot hits into the output.
    always_comb begin
        depend = flag_hit | (|slot_hit);
    end

    // Purpose: cross-check the merged output against its contributors.
    always_comb begin
        if (prv_wr_flag && nxt_rd_flag)
            assert_flag_forces_R1: assert (depend) else $error("R1 flag pair missed");
        if (!prv_has_dst && !flag_hit)
            assert_no_dst_quiet_R2: assert (!depend) else $error("R2 depend without destination");
        if (!(prv_wr_flag && nxt_rd_flag) && nxt_src_vld == '0)
            assert_no_source_quiet_R9: assert (!depend) else $error("R9 depend with no valid slot");
    end
endmodule

// File: tb/dep_hazard_check_test.sv
module dep_hazard_check_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prv_has_dst = 1'b0;
    logic [4:0]  prv_dst_reg = '0;
    logic        prv_dst_mem = 1'b0;
    logic        prv_wr_flag = 1'b0;
    logic [2:0]  nxt_src_vld = '0;
    logic [14:0] nxt_src_reg = '0;
    logic [5:0]  nxt_src_kind = '0;
    logic        nxt_rd_flag = 1'b0;
    logic        depend;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;
    string tag = "R10";

    always #2 clk = ~clk;

    dep_hazard_check uut (
        .prv_has_dst (prv_has_dst),
        .prv_dst_reg (prv_dst_reg),
        .prv_dst_mem (prv_dst_mem),
        .prv_wr_flag (prv_wr_flag),
        .nxt_src_vld (nxt_src_vld),
        .nxt_src_reg (nxt_src_reg),
        .nxt_src_kind(nxt_src_kind),
        .nxt_rd_flag (nxt_rd_flag),
        .depend      (depend)
    );

    // Behavioural reference built straight from the requirements.
    function automatic bit model();
        bit r = 0;
        if (prv_wr_flag && nxt_rd_flag) r = 1;                 // R1
        if (prv_has_dst) begin                                  // R2
            for (int s = 0; s < 3; s++) begin
                int k  = int'(nxt_src_kind >> (2*s)) & 3;       // R9 layout
                int rg = int'(nxt_src_reg >> (5*s)) & 31;
                if (!nxt_src_vld[s]) continue;                  // R3
                if (k == 1 && !prv_dst_mem && rg == int'(prv_dst_reg)) r = 1; // R4, R6
                if (k == 2 && (prv_dst_mem || rg == int'(prv_dst_reg))) r = 1; // R5, R7
            end
        end
        return r;
    endfunction

    // Compare on every clock, away from the rising edge.
    always @(negedge clk) begin
        if (!done) begin
            bit exp;
            exp = (rst_n) ? model() : 1'b0;
            n_chk++;
            if (depend !== exp) begin
                n_bad++;
                $display("FAIL %s: depend=%0b expected=%0b", tag, depend, exp);
            end
        end
    end

    task automatic drive(input string t, input bit hd, input int dr, input bit dm,
                         input bit wf, input bit [2:0] v, input bit [14:0] rg,
                         input bit [5:0] kd, input bit rf);
        @(posedge clk);
        #1;
        tag = t;
        prv_has_dst = hd; prv_dst_reg = 5'(dr); prv_dst_mem = dm; prv_wr_flag = wf;
        nxt_src_vld = v; nxt_src_reg = rg; nxt_src_kind = kd; nxt_rd_flag = rf;
    endtask

    function automatic bit [14:0] regs(input int a, input int b, input int c);
        return {5'(c), 5'(b), 5'(a)};
    endfunction

    initial begin
        // Reset phase: all descriptors zero, output must be 0 (R10).
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: flag pair with no destination and immediates only
        drive("R1", 0, 0, 0, 1, 3'b111, regs(4,4,4), 6'b000000, 1);
        drive("R1", 1, 9, 1, 1, 3'b000, regs(0,0,0), 6'b000000, 1);
        drive("R1", 0, 0, 0, 1, 3'b000, regs(0,0,0), 6'b000000, 0);
        // R2: no destination, matching registers
        drive("R2", 0, 7, 0, 0, 3'b111, regs(7,7,7), 6'b100101, 0);
        // R3: immediates, invalid slots, reserved kind
        drive("R3", 1, 7, 0, 0, 3'b111, regs(7,7,7), 6'b000000, 0);
        drive("R3", 1, 7, 1, 0, 3'b000, regs(7,7,7), 6'b101010, 0);
        drive("R3", 1, 7, 0, 0, 3'b111, regs(7,7,7), 6'b111111, 0);
        // R4: register vs plain register
        drive("R4", 1, 12, 0, 0, 3'b001, regs(12,0,0), 6'b000001, 0);
        drive("R4", 1, 12, 0, 0, 3'b001, regs(13,0,0), 6'b000001, 0);
        // R5: register vs base register
        drive("R5", 1, 3, 0, 0, 3'b010, regs(0,3,0), 6'b001000, 0);
        drive("R5", 1, 3, 0, 0, 3'b010, regs(0,30,0), 6'b001000, 0);
        // R6: store vs plain read, equal numbers
        drive("R6", 1, 5, 1, 0, 3'b111, regs(5,5,5), 6'b010101, 0);
        // R7: store vs base, different numbers
        drive("R7", 1, 5, 1, 0, 3'b100, regs(0,0,22), 6'b100000, 0);
        drive("R7", 1, 5, 1, 0, 3'b100, regs(0,0,5), 6'b100000, 0);
        // R8: register 0 compared normally; younger store base as kind 2
        drive("R8", 1, 0, 0, 0, 3'b001, regs(0,0,0), 6'b000001, 0);
        drive("R8", 1, 0, 0, 0, 3'b001, regs(1,0,0), 6'b000001, 0);
        drive("R8", 1, 17, 0, 0, 3'b011, regs(2,17,0), 6'b001000, 0);
        // R9: a single hit in each slot position
        for (int s = 0; s < 3; s++) begin
            drive("R9", 1, 21, 0, 0, 3'b111,
                  15'(21 << (5*s)) | 15'(~(31 << (5*s)) & 15'h7fff & 15'h0000),
                  6'b010101, 0);
        end
        drive("R9", 1, 21, 0, 0, 3'b110, regs(21,1,2), 6'b010101, 0);
        // R10: output follows inputs each cycle with no memory
        drive("R10", 1, 9, 0, 0, 3'b001, regs(9,0,0), 6'b000001, 0);
        drive("R10", 1, 9, 0, 0, 3'b001, regs(8,0,0), 6'b000001, 0);
        // R9: pseudo-random sweep against the model
        for (int i = 0; i < 600; i++) begin
            drive("R9", 1'($urandom), int'($urandom % 4), 1'($urandom), 1'($urandom),
                  3'($urandom), 15'($urandom) & 15'h3def | 15'($urandom % 4),
                  6'($urandom), 1'($urandom));
        end
        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule